// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits beside the control logic of a byte-wide parallel flash model and watches every host write cycle (address, data, one-cycle write strobe). It recognises the multi-cycle unlock sequences that share the common `AA`/`55` prefix. From them it produces one-cycle command pulses for the neighbouring erase and lock logic, and it keeps the mode flags: software write protection, identification mode and the two boot-region locks.

While identification mode is active, the block also answers reads at the four identification addresses with the maker code, the device code and the lock status of each boot region. The page buffer, the array, the write timing and data polling are all handled elsewhere. Neighbours see only the pulses and the flag levels.

Top module: `flash_cmd_decoder`

## Requirements
- R1: Only write-address bits 14..0 are compared when a cycle is matched. The unlock addresses are 5555h (step A) and 2AAAh (step B), so bits 17..15 of the address do not affect matching.
- R2: The writes AA@5555, 55@2AAA, A0@5555 produce a `prot_on` pulse and set `prot_en` to 1. When protection is on, the pulse also marks the start of the next page load.
- R3: The writes AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 20@5555 produce a `prot_off` pulse and clear `prot_en` to 0.
- R4: The six-write sequence ending in 10@5555 produces an `erase_req` pulse when neither boot region is locked.
- R5: The chip-erase sequence produces no pulse while either boot region is locked.
- R6: Identification mode is entered by the three-write sequence ending in 90@5555 or by the six-write sequence ending in 60@5555. It is left by the three-write sequence ending in F0@5555. `id_mode` shows the current mode.
- R7: In identification mode, a read is answered with `rd_valid`=1 and the following data: DAh at address 00000h, 45h at 00001h, FFh (locked) or FEh (unlocked) for the low region at 00002h, and the same FFh/FEh encoding for the high region at 3FFF2h.
- R8: The six-write prefix ending in 40@5555, followed by a seventh write, sets a region lock. The seventh write 00@00000 locks the low region and gives a `lock_lo` pulse. The seventh write FF@3FFFF (low 15 bits 7FFFh) locks the high region and gives a `lock_hi` pulse. Both `lock_*` pulses are compared on bits 14..0.
- R9: After power-up, `prot_en` is 1 and both lock flags are 0. Reset clears `id_mode`, the pulses and the sequencer. Reset leaves `prot_en` and both lock flags unchanged.
- R10: A write that is not the expected next step returns the sequencer to idle with no pulse. If that write is AA@5555, it counts as step one of a new sequence.
- R11: Each command pulse lasts one cycle. It appears in the cycle after the strobe of the final write, and the flags change at the same edge. Idle cycles between writes of a sequence are allowed. At most one pulse is high at a time.
- R12: Outside identification mode, or at any other address, a read gives `rd_valid`=0 and `rd_data`=00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_addr | input | 18 | Host write address |
| wr_data | input | 8 | Host write data |
| rd_addr | input | 18 | Host read address |
| rd_data | output | 8 | Identification read data |
| rd_valid | output | 1 | Read hit an identification address while in ID mode |
| erase_req | output | 1 | Chip-erase command pulse |
| prot_on | output | 1 | Protection-on / load-arm pulse |
| prot_off | output | 1 | Protection-off pulse |
| lock_lo | output | 1 | Low boot region lock pulse |
| lock_hi | output | 1 | High boot region lock pulse |
| prot_en | output | 1 | Software write protection level |
| id_mode | output | 1 | Identification mode level |
| boot_lo_locked | output | 1 | Low boot region lock level |
| boot_hi_locked | output | 1 | High boot region lock level |

## Verification
Every result is one register away from its stimulus. A command pulse and the flag it changes are both due in the cycle after the strobe of the final write. Read data is due in the cycle after `rd_addr` is applied. The bench drives inputs on the falling edge and lets one rising edge pass. It samples on the next falling edge, so every check lands in the single cycle where the result is due. One extra cycle is sampled to confirm that the pulse has dropped again.

// File: rtl/fcd_pkg.sv
// Shared types and command byte values for the flash command decoder.
package fcd_pkg;

    // Sequencer position inside the unlock sequence tree.
    typedef enum logic [2:0] {
        SQ_IDLE  = 3'd0,   // waiting for the first unlock write
        SQ_U1    = 3'd1,   // saw AA at address A
        SQ_U2    = 3'd2,   // saw 55 at address B
        SQ_X3    = 3'd3,   // saw the extension byte 80
        SQ_X4    = 3'd4,   // saw the second AA
        SQ_X5    = 3'd5,   // saw the second 55
        SQ_BOOT  = 3'd6    // saw 40, waiting for the region select write
    } seq_state_t;

    // Decoded command for one write cycle.
    typedef enum logic [2:0] {
        CMD_NONE     = 3'd0,
        CMD_PROT_ON  = 3'd1,
        CMD_PROT_OFF = 3'd2,
        CMD_ERASE    = 3'd3,
        CMD_ID_ENTER = 3'd4,
        CMD_ID_EXIT  = 3'd5,
        CMD_LOCK_LO  = 3'd6,
        CMD_LOCK_HI  = 3'd7
    } cmd_t;

    localparam logic [7:0] KEY_FIRST  = 8'hAA;
    localparam logic [7:0] KEY_SECOND = 8'h55;
    localparam logic [7:0] OP_PROT_ON = 8'hA0;
    localparam logic [7:0] OP_EXTEND  = 8'h80;
    localparam logic [7:0] OP_ID_IN3  = 8'h90;
    localparam logic [7:0] OP_ID_OUT  = 8'hF0;
    localparam logic [7:0] OP_UNPROT  = 8'h20;
    localparam logic [7:0] OP_ERASE   = 8'h10;
    localparam logic [7:0] OP_ID_IN6  = 8'h60;
    localparam logic [7:0] OP_BOOT    = 8'h40;
    localparam logic [7:0] SEL_LO     = 8'h00;
    localparam logic [7:0] SEL_HI     = 8'hFF;

endpackage

// File: rtl/fcd_cycle_class.sv
// Classifies one host write cycle by its compared address bits.
// Assumes: CMP_W <= ADDR_W; the unlock addresses fit in CMP_W bits.
module fcd_cycle_class #(
    parameter int ADDR_W = 18,
    parameter int CMP_W  = 15
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        data,
    output logic              at_a,
    output logic              at_b,
    output logic              at_lo,
    output logic              at_hi,
    output logic              key1,
    output logic              key2
);
    localparam logic [CMP_W-1:0] UNLK_A = CMP_W'(16'h5555);
    localparam logic [CMP_W-1:0] UNLK_B = CMP_W'(16'h2AAA);
    localparam logic [CMP_W-1:0] LO_END = '0;
    localparam logic [CMP_W-1:0] HI_END = '1;

    logic [CMP_W-1:0] cmp_addr;

    // Address window compare on the low CMP_W bits only.
    always_comb begin
        cmp_addr = addr[CMP_W-1:0];
        at_a     = (cmp_addr == UNLK_A);
        at_b     = (cmp_addr == UNLK_B);
        at_lo    = (cmp_addr == LO_END);
        at_hi    = (cmp_addr == HI_END);
        key1     = at_a && (data == fcd_pkg::KEY_FIRST);
        key2     = at_b && (data == fcd_pkg::KEY_SECOND);
    end
endmodule

// File: rtl/fcd_sequencer.sv
// Walks the shared unlock prefix tree and names the command a write completes.
// Assumes: wr_en is high for exactly one cycle per host write.
module fcd_sequencer (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [7:0]    data,
    input  logic          at_a,
    input  logic          at_lo,
    input  logic          at_hi,
    input  logic          key1,
    input  logic          key2,
    output fcd_pkg::cmd_t cmd
);
    import fcd_pkg::*;

    seq_state_t state_q, state_d;
    seq_state_t restart;

    // Next step and completed command for the current write.
    always_comb begin
        restart = key1 ? SQ_U1 : SQ_IDLE;
        state_d = state_q;
        cmd     = CMD_NONE;
        if (wr_en) begin
            state_d = restart;
            unique case (state_q)
                SQ_IDLE: state_d = restart;
                SQ_U1:   if (key2) state_d = SQ_U2;
                SQ_U2: begin
                    if (at_a) begin
                        if (data == OP_PROT_ON)      begin cmd = CMD_PROT_ON;  state_d = SQ_IDLE; end
                        else if (data == OP_ID_IN3)  begin cmd = CMD_ID_ENTER; state_d = SQ_IDLE; end
                        else if (data == OP_ID_OUT)  begin cmd = CMD_ID_EXIT;  state_d = SQ_IDLE; end
                        else if (data == OP_EXTEND)  state_d = SQ_X3;
                    end
                end
                SQ_X3:   if (key1) state_d = SQ_X4;
                SQ_X4:   if (key2) state_d = SQ_X5;
                SQ_X5: begin
                    if (at_a) begin
                        if (data == OP_UNPROT)       begin cmd = CMD_PROT_OFF; state_d = SQ_IDLE; end
                        else if (data == OP_ERASE)   begin cmd = CMD_ERASE;    state_d = SQ_IDLE; end
                        else if (data == OP_ID_IN6)  begin cmd = CMD_ID_ENTER; state_d = SQ_IDLE; end
                        else if (data == OP_BOOT)    state_d = SQ_BOOT;
                    end
                end
                SQ_BOOT: begin
                    if (at_lo && data == SEL_LO)      begin cmd = CMD_LOCK_LO; state_d = SQ_IDLE; end
                    else if (at_hi && data == SEL_HI) begin cmd = CMD_LOCK_HI; state_d = SQ_IDLE; end
                end
                default: state_d = SQ_IDLE;
            endcase
        end
    end

    // Sequencer position register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else        state_q <= state_d;
    end

    // The region select step is reached only from the second 55 step.
    assert_boot_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_BOOT && $past(state_q) != SQ_BOOT) |-> $past(state_q) == SQ_X5);

    // Without a strobe the sequencer holds its position (gaps allowed).
    assert_hold_without_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_en)) |-> $stable(state_q));
endmodule

// File: rtl/fcd_mode_regs.sv
// Turns decoded commands into one-cycle pulses and keeps the mode flags.
// Assumes: protection and lock flags model non-volatile state, so reset
// leaves them alone; their power-up values come from declaration.
module fcd_mode_regs (
    input  logic          clk,
    input  logic          rst_n,
    input  fcd_pkg::cmd_t cmd,
    output logic          erase_req,
    output logic          prot_on,
    output logic          prot_off,
    output logic          lock_lo,
    output logic          lock_hi,
    output logic          prot_en,
    output logic          id_mode,
    output logic          lo_locked,
    output logic          hi_locked
);
    import fcd_pkg::*;

    logic prot_q   = 1'b1;
    logic lo_lck_q = 1'b0;
    logic hi_lck_q = 1'b0;
    logic any_lock;

    // Any locked region disables chip erase.
    always_comb any_lock = lo_lck_q || hi_lck_q;

    // Persistent flags, updated only outside reset.
    always_ff @(posedge clk) begin
        if (rst_n) begin
            if (cmd == CMD_PROT_ON)  prot_q   <= 1'b1;
            if (cmd == CMD_PROT_OFF) prot_q   <= 1'b0;
            if (cmd == CMD_LOCK_LO)  lo_lck_q <= 1'b1;
            if (cmd == CMD_LOCK_HI)  hi_lck_q <= 1'b1;
        end
    end

    // One-cycle command pulses and the volatile ID mode flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            erase_req <= 1'b0;
            prot_on   <= 1'b0;
            prot_off  <= 1'b0;
            lock_lo   <= 1'b0;
            lock_hi   <= 1'b0;
            id_mode   <= 1'b0;
        end else begin
            erase_req <= (cmd == CMD_ERASE) && !any_lock;
            prot_on   <= (cmd == CMD_PROT_ON);
            prot_off  <= (cmd == CMD_PROT_OFF);
            lock_lo   <= (cmd == CMD_LOCK_LO);
            lock_hi   <= (cmd == CMD_LOCK_HI);
            if (cmd == CMD_ID_ENTER)     id_mode <= 1'b1;
            else if (cmd == CMD_ID_EXIT) id_mode <= 1'b0;
        end
    end

    always_comb begin
        prot_en   = prot_q;
        lo_locked = lo_lck_q;
        hi_locked = hi_lck_q;
    end

    assert_pulse_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({erase_req, prot_on, prot_off, lock_lo, lock_hi}));

    assert_no_erase_when_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> !(lo_locked || hi_locked));

    assert_lo_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lo_locked |=> lo_locked);

    assert_hi_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hi_locked |=> hi_locked);

    assert_prot_rise_with_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_en) |-> prot_on);
endmodule

// File: rtl/fcd_id_port.sv
// Answers identification reads with codes and region lock status.
// Assumes: read data is wanted one cycle after the address is applied.
module fcd_id_port #(
    parameter int         ADDR_W   = 18,
    parameter logic [7:0] MFR_CODE = 8'hDA,
    parameter logic [7:0] DEV_CODE = 8'h45
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              id_mode,
    input  logic              lo_locked,
    input  logic              hi_locked,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              rd_valid
);
    localparam logic [ADDR_W-1:0] A_MFR    = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_DEV    = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_LO_ST  = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_HI_ST  = {ADDR_W{1'b1}} - ADDR_W'(13);
    localparam logic [7:0]        ST_LOCK  = 8'hFF;
    localparam logic [7:0]        ST_OPEN  = 8'hFE;

    logic [7:0] data_d;
    logic       hit_d;

    // Address decode of the identification window.
    always_comb begin
        hit_d  = id_mode;
        data_d = 8'h00;
        if (rd_addr == A_MFR)        data_d = MFR_CODE;
        else if (rd_addr == A_DEV)   data_d = DEV_CODE;
        else if (rd_addr == A_LO_ST) data_d = lo_locked ? ST_LOCK : ST_OPEN;
        else if (rd_addr == A_HI_ST) data_d = hi_locked ? ST_LOCK : ST_OPEN;
        else                         hit_d  = 1'b0;
        if (!hit_d) data_d = 8'h00;
    end

    // Registered read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= 8'h00;
            rd_valid <= 1'b0;
        end else begin
            rd_data  <= data_d;
            rd_valid <= hit_d;
        end
    end

    assert_valid_needs_mode_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(id_mode));

    assert_quiet_when_invalid_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> rd_data == 8'h00);
endmodule

// File: rtl/flash_cmd_decoder.sv
// Top of the flash command decoder: classify, sequence, register, answer.
// Assumes: one-cycle write strobe; reads are side-effect free.
module flash_cmd_decoder #(
    parameter int ADDR_W = 18,
    parameter int CMP_W  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    output logic              erase_req,
    output logic              prot_on,
    output logic              prot_off,
    output logic              lock_lo,
    output logic              lock_hi,
    output logic              prot_en,
    output logic              id_mode,
    output logic              boot_lo_locked,
    output logic              boot_hi_locked
);
    logic          at_a, at_b, at_lo, at_hi, key1, key2;
    fcd_pkg::cmd_t cmd;

    fcd_cycle_class #(.ADDR_W(ADDR_W), .CMP_W(CMP_W)) u_class (
        .addr  (wr_addr),
        .data  (wr_data),
        .at_a  (at_a),
        .at_b  (at_b),
        .at_lo (at_lo),
        .at_hi (at_hi),
        .key1  (key1),
        .key2  (key2)
    );

    fcd_sequencer u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .data  (wr_data),
        .at_a  (at_a),
        .at_lo (at_lo),
        .at_hi (at_hi),
        .key1  (key1),
        .key2  (key2),
        .cmd   (cmd)
    );

    fcd_mode_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .erase_req (erase_req),
        .prot_on   (prot_on),
        .prot_off  (prot_off),
        .lock_lo   (lock_lo),
        .lock_hi   (lock_hi),
        .prot_en   (prot_en),
        .id_mode   (id_mode),
        .lo_locked (boot_lo_locked),
        .hi_locked (boot_hi_locked)
    );

    fcd_id_port #(.ADDR_W(ADDR_W)) u_id (
        .clk       (clk),
        .rst_n     (rst_n),
        .id_mode   (id_mode),
        .lo_locked (boot_lo_locked),
        .hi_locked (boot_hi_locked),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

    // A pulse only ever follows a write strobe by one cycle.
    assert_pulse_after_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req || prot_on || prot_off || lock_lo || lock_hi) |-> $past(wr_en));

    // Bit 14 is compared, so 5555h aliases do not carry into other command bits
    // beyond the compare window: a pulse requires an unlock address on the last write.
    assert_prot_on_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        prot_on |-> $past(wr_addr[CMP_W-1:0]) == CMP_W'(16'h5555));
endmodule

// File: tb/tb_flash_cmd_decoder.sv
`timescale 1ns/1ps
module tb_flash_cmd_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [17:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [17:0] rd_addr = '0;
    logic [7:0]  rd_data;
    logic        rd_valid, erase_req, prot_on, prot_off, lock_lo, lock_hi;
    logic        prot_en, id_mode, boot_lo_locked, boot_hi_locked;

    int checks = 0;
    int errors = 0;
    logic [4:0] pl;   // {erase_req, prot_on, prot_off, lock_lo, lock_hi}

    localparam logic [4:0] P_NONE = 5'b00000, P_ERASE = 5'b10000, P_ON = 5'b01000,
                           P_OFF = 5'b00100, P_LO = 5'b00010, P_HI = 5'b00001;

    always #2.5 clk = ~clk;

    flash_cmd_decoder dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
        .erase_req(erase_req), .prot_on(prot_on), .prot_off(prot_off),
        .lock_lo(lock_lo), .lock_hi(lock_hi), .prot_en(prot_en), .id_mode(id_mode),
        .boot_lo_locked(boot_lo_locked), .boot_hi_locked(boot_hi_locked)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One write; pl holds the pulses in the cycle after its strobe.
    task automatic wr(input logic [17:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        pl = {erase_req, prot_on, prot_off, lock_lo, lock_hi};
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic seq3(input logic [7:0] op);
        wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55); wr(18'h05555, op);
    endtask

    task automatic seq6(input logic [7:0] op);
        wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55); wr(18'h05555, 8'h80);
        wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55); wr(18'h05555, op);
    endtask

    task automatic rd(input logic [17:0] a, input string req,
                      input logic v, input logic [7:0] d);
        @(negedge clk);
        rd_addr = a;
        @(posedge clk);
        @(negedge clk);
        chk(req, {23'd0, rd_valid, rd_data}, {23'd0, v, d});
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        idle(1);
        chk("R9 power-up prot_en", prot_en, 1);
        chk("R9 power-up locks", {boot_lo_locked, boot_hi_locked}, 0);
        chk("R9 reset id_mode and pulses", {id_mode, erase_req, prot_on, prot_off, lock_lo, lock_hi}, 0);
    endtask

    task automatic t_prot_off();
        seq6(8'h20);
        chk("R3 prot_off pulse", pl, P_OFF);
        chk("R3 prot_en cleared", prot_en, 0);
    endtask

    task automatic t_prot_on_alias();
        wr(18'h0D555, 8'hAA); wr(18'h2AAAA, 8'h55); wr(18'h35555, 8'hA0);
        chk("R1 R2 prot_on pulse with upper address bits set", pl, P_ON);
        chk("R2 prot_en set", prot_en, 1);
    endtask

    task automatic t_erase_open();
        seq6(8'h10);
        chk("R4 erase pulse when unlocked", pl, P_ERASE);
    endtask

    task automatic t_id3();
        seq3(8'h90);
        chk("R6 id entry by three writes", id_mode, 1);
        chk("R6 id entry gives no pulse", pl, P_NONE);
        rd(18'h00000, "R7 maker code", 1, 8'hDA);
        rd(18'h00001, "R7 device code", 1, 8'h45);
        rd(18'h00002, "R7 low region open", 1, 8'hFE);
        rd(18'h3FFF2, "R7 high region open", 1, 8'hFE);
        rd(18'h00003, "R12 other address in id mode", 0, 8'h00);
        seq3(8'hF0);
        chk("R6 id exit", id_mode, 0);
        rd(18'h00000, "R12 read outside id mode", 0, 8'h00);
    endtask

    task automatic t_id6_reset();
        seq6(8'h60);
        chk("R6 id entry by six writes", id_mode, 1);
        seq6(8'h20);
        chk("R3 prot_off in id mode", prot_en, 0);
        do_reset();
        idle(1);
        chk("R9 reset clears id_mode", id_mode, 0);
        chk("R9 reset keeps prot_en", prot_en, 0);
    endtask

    task automatic t_mismatch();
        wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55); wr(18'h05555, 8'h33);
        chk("R10 wrong opcode no pulse", pl, P_NONE);
        wr(18'h02AAA, 8'h55); wr(18'h05555, 8'hA0);
        chk("R10 sequencer back in idle", {pl, prot_en}, {P_NONE, 1'b0});
        wr(18'h05555, 8'hAA);
        wr(18'h05555, 8'hAA);
        idle(4);
        wr(18'h02AAA, 8'h55);
        idle(2);
        wr(18'h05555, 8'hA0);
        chk("R10 R11 AA restart and gaps give prot_on", pl, P_ON);
        idle(1);
        chk("R11 pulse lasts one cycle", {erase_req, prot_on, prot_off, lock_lo, lock_hi}, 0);
    endtask

    task automatic t_locks();
        seq6(8'h40); wr(18'h00000, 8'h00);
        chk("R8 low lock pulse", pl, P_LO);
        chk("R8 low lock level", {boot_lo_locked, boot_hi_locked}, 2'b10);
        seq3(8'h90);
        rd(18'h00002, "R7 low region locked", 1, 8'hFF);
        rd(18'h3FFF2, "R7 high region still open", 1, 8'hFE);
        seq3(8'hF0);
        seq6(8'h40); wr(18'h3FFFF, 8'hFF);
        chk("R8 high lock pulse", pl, P_HI);
        do_reset();
        idle(1);
        chk("R9 locks survive reset", {boot_lo_locked, boot_hi_locked}, 2'b11);
    endtask

    task automatic t_erase_locked();
        seq6(8'h10);
        chk("R5 erase ignored when locked", pl, P_NONE);
        chk("R5 flags unchanged", {prot_en, boot_lo_locked, boot_hi_locked}, 3'b111);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        t_reset_state();
        t_prot_off();
        t_prot_on_alias();
        t_erase_open();
        t_id3();
        t_id6_reset();
        t_mismatch();
        t_locks();
        t_erase_locked();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule